// File: doc/BRIEF.md
# Regulator Control Register Bank

This block holds the settings for a set of nine linear regulators: one output-voltage code per rail and one enable word with a bit per rail. A host writes and reads it through a plain port with address, write strobe and data. The serial bus that fronts this port is out of scope, and so is the conversion of codes into voltages. Every code and enable bit drives an output pin straight from a flop.

Two strap pins pick the power-up voltages of the core and pad rails. They are sampled only while reset is asserted. A host hold input keeps the programmed settings alive. While it is low, every register returns to its power-up value, using the strap values captured at reset, and writes are refused. Turning a rail off and on again through the enable word does not disturb its voltage code.

Voltage codes are 5-bit: code n means 1.35 V + n × 50 mV, so code 0 is 1.35 V and code 31 is 2.90 V. Rail numbering and register addresses: 0 core, 1 pad, 2 camera, 3 motor, 4 to 8 low-noise analog rails, 9 enable word, 10 to 15 unmapped.

Top module: `rail_ctrl_bank`

## Requirements
- R1: After reset, the codes and enables hold their power-up values. Core is 9 (1.80 V) with strap_core high and 0 (1.35 V) with it low. Pad is 25 (2.60 V) with strap_pad high and 9 (1.80 V) with it low. Camera is 29, motor is 21, each analog rail is 30. rail_en is 9'h033, meaning core, pad and the first two analog rails are on.
- R2: A write to address i (0 to 8) sets the code of rail i, which appears on rail_code[5i+4:5i]. No other rail changes.
- R3: A write to address 9 loads rail_en from wr_data[8:0] in one step, where bit i enables rail i. wr_data[15:9] is ignored.
- R4: Writing the enable word leaves every voltage code unchanged.
- R5: Written values are clamped to the rail's range. For analog rails 4 to 8 the range is 24 to 31 (2.55 V to 2.90 V). For rails 0 to 3 it is 0 to 31. A value below the floor becomes the floor, and a value above 31 becomes 31.
- R6: In any cycle where hold is sampled low, every code and enable reloads its power-up value, and a write offered in that cycle is dropped.
- R7: The straps are captured only during reset. Changing them later has no effect, including on the values a hold-low reload restores.
- R8: rd_data shows, one clock after addr is sampled, the register at that address as it stood before that edge, zero-extended. Address 9 returns the enable word.
- R9: Addresses 10 to 15 read as zero, and writes to them change nothing.
- R10: rail_code and rail_en change only on the clock edge that takes a write or a hold-low reload, never combinationally from the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; straps sampled while high |
| hold | input | 1 | Host hold; low reloads power-up values |
| strap_core | input | 1 | Core default select strap |
| strap_pad | input | 1 | Pad default select strap |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| rail_en | output | 9 | Enable per rail |
| rail_code | output | 45 | Voltage code per rail, rail i in bits [5i+4:5i] |

## Verification
The bench uses the default parameters: nine rails, 5-bit codes, a 4-bit address and 16-bit data. At this size it can write every value from 0 to 40, plus all-ones, into every rail, which covers both clamp edges of the analog and digital ranges. It can also drive all 512 enable patterns and check after each that no code moved. All four strap combinations, every unmapped address, and hold reloads after the straps have changed are also within reach.

// File: rtl/rail_bank_pkg.sv
package rail_bank_pkg;

  // Limits a value to the closed range [lo, hi].
  function automatic logic [31:0] clamp_range(logic [31:0] v, logic [31:0] lo, logic [31:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins,
  output logic [N-1:0] sel
);

  logic [N-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= pins;
  end

  // During reset the live pins feed the defaults, so that the reset load matches the capture.
  assign sel = rst ? pins : held;

  // R7: the selection never moves once reset has dropped.
  a_r7_strap_frozen: assert property (@(posedge clk) disable iff (rst) $stable(sel));

endmodule

// File: rtl/rail_code_reg.sv
module rail_code_reg
  import rail_bank_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int DATA_W = 16,
  parameter int LO     = 0,
  parameter int HI     = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [CODE_W-1:0] def_code,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] clamped;

  always_comb begin
    clamped = CODE_W'(clamp_range(32'(wr_data), 32'(LO), 32'(HI)));
  end

  always_ff @(posedge clk) begin
    if (rst || !hold)  code <= def_code;
    else if (wr_hit)   code <= clamped;
  end

  // R4 / R10: without a write or reload the code holds.
  a_r4_code_hold: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_hit) |=> $stable(code));

  // R6: hold low restores the power-up code.
  a_r6_code_reload: assert property (@(posedge clk) disable iff (rst)
    !hold |=> code == $past(def_code));

  generate
    if (LO > 0) begin : g_floor
      // R5: an analog code never sits below its floor.
      a_r5_code_floor: assert property (@(posedge clk) disable iff (rst)
        32'(code) >= 32'(LO));
    end
  endgenerate

endmodule

// File: rtl/rail_enable_reg.sv
module rail_enable_reg #(
  parameter int                     NUM_RAILS  = 9,
  parameter logic [NUM_RAILS-1:0]   EN_DEFAULT = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold,
  input  logic                 wr_hit,
  input  logic [NUM_RAILS-1:0] wr_bits,
  output logic [NUM_RAILS-1:0] en
);

  always_ff @(posedge clk) begin
    if (rst || !hold) en <= EN_DEFAULT;
    else if (wr_hit)  en <= wr_bits;
  end

  // R3: one write sets every bit at once.
  a_r3_enable_load: assert property (@(posedge clk) disable iff (rst)
    (hold && wr_hit) |=> en == $past(wr_bits));

  // R6: hold low restores the power-up enables.
  a_r6_enable_reload: assert property (@(posedge clk) disable iff (rst)
    !hold |=> en == EN_DEFAULT);

  // R10: no write, no change.
  a_r10_enable_hold: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_hit) |=> $stable(en));

endmodule

// File: rtl/regbank_readback.sv
module regbank_readback #(
  parameter int NUM_RAILS = 9,
  parameter int CODE_W    = 5,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_RAILS*CODE_W-1:0] codes,
  input  logic [NUM_RAILS-1:0]        en,
  output logic [DATA_W-1:0]           rd_data
);

  localparam int EN_ADDR = NUM_RAILS;

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_RAILS; i++) begin
      if (addr == ADDR_W'(i)) sel = DATA_W'(codes[i*CODE_W +: CODE_W]);
    end
    if (addr == ADDR_W'(EN_ADDR)) sel = DATA_W'(en);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end

  // R9: unmapped addresses return zero on the next cycle.
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (32'(addr) > 32'(EN_ADDR)) |=> rd_data == '0);

  // R8: the enable word reads back one cycle later.
  a_r8_enable_read: assert property (@(posedge clk) disable iff (rst)
    (32'(addr) == 32'(EN_ADDR)) |=> rd_data == DATA_W'($past(en)));

endmodule

// File: rtl/rail_ctrl_bank.sv
module rail_ctrl_bank #(
  parameter int NUM_RAILS    = 9,
  parameter int CODE_W       = 5,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16,
  parameter int ANALOG_LO    = 24,
  parameter int CORE_HI_CODE = 9,
  parameter int CORE_LO_CODE = 0,
  parameter int PAD_HI_CODE  = 25,
  parameter int PAD_LO_CODE  = 9,
  parameter logic [NUM_RAILS-1:0]        ANALOG_MASK = 9'h1F0,
  parameter logic [NUM_RAILS-1:0]        EN_DEFAULT  = 9'h033,
  parameter logic [NUM_RAILS*CODE_W-1:0] DEF_CODES   =
    {5'd30, 5'd30, 5'd30, 5'd30, 5'd30, 5'd21, 5'd29, 5'd0, 5'd0}
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hold,
  input  logic                        strap_core,
  input  logic                        strap_pad,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_RAILS-1:0]        rail_en,
  output logic [NUM_RAILS*CODE_W-1:0] rail_code
);

  localparam int CORE_IDX = 0;
  localparam int PAD_IDX  = 1;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int EN_ADDR  = NUM_RAILS;

  logic [1:0] strap_sel;

  strap_latch #(.N(2)) u_straps (
    .clk  (clk),
    .rst  (rst),
    .pins ({strap_pad, strap_core}),
    .sel  (strap_sel)
  );

  generate
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      logic [CODE_W-1:0] dflt;
      logic              hit;

      if (i == CORE_IDX) begin : g_core
        assign dflt = strap_sel[0] ? CODE_W'(CORE_HI_CODE) : CODE_W'(CORE_LO_CODE);
      end else if (i == PAD_IDX) begin : g_pad
        assign dflt = strap_sel[1] ? CODE_W'(PAD_HI_CODE) : CODE_W'(PAD_LO_CODE);
      end else begin : g_fixed
        assign dflt = DEF_CODES[i*CODE_W +: CODE_W];
      end

      assign hit = wr_en && (addr == ADDR_W'(i));

      rail_code_reg #(
        .CODE_W (CODE_W),
        .DATA_W (DATA_W),
        .LO     (ANALOG_MASK[i] ? ANALOG_LO : 0),
        .HI     (CODE_MAX)
      ) u_code (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .def_code (dflt),
        .wr_hit   (hit),
        .wr_data  (wr_data),
        .code     (rail_code[i*CODE_W +: CODE_W])
      );
    end
  endgenerate

  rail_enable_reg #(
    .NUM_RAILS  (NUM_RAILS),
    .EN_DEFAULT (EN_DEFAULT)
  ) u_enable (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .wr_hit  (wr_en && (addr == ADDR_W'(EN_ADDR))),
    .wr_bits (wr_data[NUM_RAILS-1:0]),
    .en      (rail_en)
  );

  regbank_readback #(
    .NUM_RAILS (NUM_RAILS),
    .CODE_W    (CODE_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_read (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .codes   (rail_code),
    .en      (rail_en),
    .rd_data (rd_data)
  );

  // R9: a write to an unmapped address leaves every output alone.
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (hold && (32'(addr) > 32'(EN_ADDR))) |=> ($stable(rail_code) && $stable(rail_en)));

endmodule

// File: tb/rail_ctrl_bank_test.sv
module rail_ctrl_bank_test;

  localparam int NR = 9;
  localparam int CW = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold = 1'b1;
  logic        strap_core = 1'b1;
  logic        strap_pad = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [NR-1:0]    rail_en;
  logic [NR*CW-1:0] rail_code;

  int tests = 0;
  int fails = 0;
  int exp_code [NR];
  logic [NR-1:0] exp_en;
  logic cap_core, cap_pad;

  always #2 clk = ~clk;

  rail_ctrl_bank uut (
    .clk(clk), .rst(rst), .hold(hold), .strap_core(strap_core), .strap_pad(strap_pad),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .rail_en(rail_en), .rail_code(rail_code)
  );

  function automatic int dflt(int i, logic sc, logic sp);
    case (i)
      0: return sc ? 9 : 0;
      1: return sp ? 25 : 9;
      2: return 29;
      3: return 21;
      default: return 30;
    endcase
  endfunction

  function automatic int clampv(int i, int d);
    int lo = (i >= 4) ? 24 : 0;
    if (d > 31) return 31;
    if (d < lo) return lo;
    return d;
  endfunction

  task automatic chk(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic load_defaults();
    for (int i = 0; i < NR; i++) exp_code[i] = dflt(i, cap_core, cap_pad);
    exp_en = 9'h033;
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NR; i++) chk(tag, int'(rail_code[i*CW +: CW]), exp_code[i]);
    chk(tag, int'(rail_en), int'(exp_en));
  endtask

  task automatic do_reset(logic sc, logic sp);
    @(negedge clk);
    strap_core = sc; strap_pad = sp; rst = 1'b1; hold = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cap_core = sc; cap_pad = sp;
    load_defaults();
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NR) exp_code[a] = clampv(a, d);
    else if (a == NR) exp_en = 9'(d);
  endtask

  task automatic rd(string tag, int a, int expv);
    @(negedge clk);
    addr = 4'(a);
    @(negedge clk);
    chk(tag, int'(rd_data), expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 / R8: power-up values and readback for every strap combination
    for (int s = 0; s < 4; s++) begin
      do_reset(s[0], s[1]);
      check_all("R1 reset defaults");
      for (int i = 0; i < NR; i++) rd("R8 read code", i, exp_code[i]);
      rd("R8 read enable", NR, int'(exp_en));
    end

    do_reset(1'b1, 1'b1);
    // R2 / R5: every rail over a value sweep that crosses both clamp edges
    for (int i = 0; i < NR; i++) begin
      for (int d = 0; d <= 41; d++) begin
        wr(i, (d == 41) ? 16'hFFFF : d);
        check_all((i >= 4) ? "R5 analog clamp" : "R2 code write");
      end
      rd("R8 read after sweep", i, exp_code[i]);
    end

    // R3 / R4: all enable patterns with junk in the upper bits
    for (int i = 0; i < NR; i++) wr(i, 3 * i + 5);
    for (int p = 0; p < 512; p++) begin
      wr(NR, {7'h55, 9'(p)});
      chk("R3 enable pattern", int'(rail_en), p);
      check_all("R4 codes kept");
    end
    rd("R8 enable read", NR, int'(exp_en));

    // R9: unmapped writes and reads
    for (int a = NR + 1; a < 16; a++) begin
      wr(a, 16'hFFFF);
      check_all("R9 unmapped write");
      rd("R9 unmapped read", a, 0);
    end

    // R10: nothing moves before the write edge
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd2; wr_data = 16'd7;
    #1 chk("R10 before edge", int'(rail_code[2*CW +: CW]), exp_code[2]);
    @(negedge clk);
    wr_en = 1'b0; exp_code[2] = 7;
    chk("R10 after edge", int'(rail_code[2*CW +: CW]), 7);

    // R7: flip the straps while running
    @(negedge clk);
    strap_core = 1'b0; strap_pad = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R7 straps ignored");

    // R6 / R7: hold low with a write in the same cycle reloads captured defaults
    @(negedge clk);
    hold = 1'b0; wr_en = 1'b1; addr = 4'd0; wr_data = 16'd3;
    @(negedge clk);
    hold = 1'b1; wr_en = 1'b0;
    load_defaults();
    check_all("R6 hold reload");
    chk("R7 core from captured strap", int'(rail_code[CW-1:0]), 9);
    chk("R7 pad from captured strap", int'(rail_code[2*CW-1:CW]), 25);

    // R6: writes after hold returns work again
    wr(5, 26);
    check_all("R6 write after hold");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule